// File: doc/BRIEF.md
# Shifter Operand Unit

This block forms the second operand of a 32-bit integer datapath. It takes the operand field of an instruction, a source register value, the value of a register that holds a shift amount, and the current carry flag. From these it returns the shifted operand and the carry bit that the shifter produces. The whole unit is combinational, so the outputs follow the inputs within the same cycle.

There are three operand forms. In the first, the shift amount is a 5-bit field inside the operand field. In the second, the amount is read from the low byte of the amount register. In the third, an 8-bit constant is rotated right by twice a 4-bit rotate field. The block handles the corner cases for amounts of zero, exactly the data width, and above the data width. In the immediate form, an encoded amount of zero has a different meaning for each shift type.

The operand field is 12 bits wide:
- In the shift forms, bits [11:7] hold the immediate amount and bits [6:5] hold the shift type. Bits [4:0] are ignored.
- In the constant form, bits [11:8] hold the rotate field and bits [7:0] hold the constant.

Top module: `opnd_shifter`

## Requirements
- R1: Shift type field bits [6:5] select the shift: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. An amount n from 1 to 31 shifts or rotates the value by n.
- R2: For n from 1 to 31, carry_o is the last bit shifted out. That is bit 32-n for a left shift and bit n-1 for right shifts and rotates.
- R3: In the immediate form (amt_src_i=0), logical left with encoded amount 0 returns the value unchanged, and carry_o equals carry_i.
- R4: In the immediate form, an encoded amount of 0 means an amount of 32 for logical right and for arithmetic right.
- R5: In the immediate form, rotate right with encoded amount 0 is a one-bit rotate through carry. The result is {carry_i, value[31:1]} and carry_o is value[0].
- R6: In the register form (amt_src_i=1), only amt_reg_i[7:0] sets the amount, and bits [11:7] of the field are ignored. An amount of 0 returns the value unchanged with carry_o equal to carry_i, for every shift type.
- R7: Logical left by 32 gives 0 with carry_o equal to value bit 0. Logical left by more than 32 gives 0 with carry_o 0.
- R8: Logical right by 32 gives 0 with carry_o equal to value bit 31. Logical right by more than 32 gives 0 with carry_o 0.
- R9: Arithmetic right by 32 or more fills every result bit with value bit 31, and carry_o equals value bit 31.
- R10: Rotate right uses the amount modulo 32. A non-zero multiple of 32 returns the value unchanged, with carry_o equal to value bit 31.
- R11: When const_sel_i=1, the result is field bits [7:0] rotated right by twice field bits [11:8], and carry_o equals carry_i. In this form value_i, amt_reg_i and amt_src_i are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| const_sel_i | input | 1 | 1 selects the rotated 8-bit constant form |
| amt_src_i | input | 1 | 0: amount taken from the field, 1: amount taken from amt_reg_i[7:0] |
| field_i | input | 12 | Instruction operand field |
| value_i | input | 32 | Register value to be shifted |
| amt_reg_i | input | 32 | Value of the register that holds the shift amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The unit holds no state. A fault in the decode from amount to operation therefore shows up on the same cycle as a wrong result_o or carry_o for the input pattern that triggers it. Such faults are most likely at the amount boundaries: 0, 1, 31, 32, 33 and 255. They are also likely when an encoded zero is remapped, and where the carry comes from the flag instead of the value. For that reason the vectors place a distinct bit pattern at each candidate carry position, and they drive carry_i opposite to the expected carry_o wherever possible. A swapped source then cannot stay hidden.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_type_e;

  // canonical operation handed from the decoder to the barrel core
  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_LSL  = 3'd1,
    OP_LSR  = 3'd2,
    OP_ASR  = 3'd3,
    OP_ROR  = 3'd4,
    OP_RRX  = 3'd5
  } core_op_e;

  function automatic core_op_e type_to_op(sh_type_e t);
    case (t)
      SH_LSL:  return OP_LSL;
      SH_LSR:  return OP_LSR;
      SH_ASR:  return OP_ASR;
      default: return OP_ROR;
    endcase
  endfunction

endpackage

// File: rtl/shamt_decode.sv
module shamt_decode
  import opshift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 12,
  parameter int CNT_W   = 8
) (
  input  logic [FIELD_W-1:0] field_i,
  input  logic               amt_src_i,
  input  logic [DATA_W-1:0]  amt_reg_i,
  output core_op_e           op_o,
  output logic [CNT_W-1:0]   cnt_o
);

  localparam int IMM_AMT_W = $clog2(DATA_W);
  localparam int AMT_LSB   = FIELD_W - IMM_AMT_W;
  localparam int TYPE_LSB  = AMT_LSB - 2;

  sh_type_e               sh_type;
  logic [IMM_AMT_W-1:0]   imm_amt;
  logic [CNT_W-1:0]       reg_amt;

  assign sh_type = sh_type_e'(field_i[TYPE_LSB +: 2]);
  assign imm_amt = field_i[AMT_LSB +: IMM_AMT_W];
  assign reg_amt = amt_reg_i[CNT_W-1:0];

  logic unused_bits;
  assign unused_bits = ^{field_i[TYPE_LSB-1:0], amt_reg_i[DATA_W-1:CNT_W]};

  always_comb begin
    op_o  = OP_PASS;
    cnt_o = '0;
    if (amt_src_i) begin
      cnt_o = reg_amt;
      op_o  = (reg_amt == '0) ? OP_PASS : type_to_op(sh_type);
    end else if (imm_amt == '0) begin
      // encoded zero is remapped per shift type
      case (sh_type)
        SH_LSL: begin op_o = OP_PASS; cnt_o = '0;             end
        SH_LSR: begin op_o = OP_LSR;  cnt_o = CNT_W'(DATA_W); end
        SH_ASR: begin op_o = OP_ASR;  cnt_o = CNT_W'(DATA_W); end
        default: begin op_o = OP_RRX; cnt_o = CNT_W'(1);      end
      endcase
    end else begin
      op_o  = type_to_op(sh_type);
      cnt_o = CNT_W'(imm_amt);
    end
  end

  // the core must never see a zero amount for a real shift
  always_comb begin
    if (op_o == OP_LSL || op_o == OP_LSR || op_o == OP_ASR || op_o == OP_ROR)
      assert_nonzero_amt_R6: assert (cnt_o != '0)
        else $error("shift op issued with zero amount");
  end

endmodule

// File: rtl/barrel_core.sv
module barrel_core
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  core_op_e          op_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);

  localparam int ROT_W = $clog2(DATA_W);

  logic [DATA_W:0]        lsl_w;
  logic [DATA_W:0]        lsr_w;
  logic signed [DATA_W:0] asr_w;
  logic [ROT_W-1:0]       rot;
  logic [DATA_W-1:0]      ror_w;

  // one spare bit beside the data catches the last bit shifted out
  assign lsl_w = {1'b0, val_i} << cnt_i;
  assign lsr_w = {val_i, 1'b0} >> cnt_i;
  assign asr_w = $signed({val_i, 1'b0}) >>> cnt_i;
  assign rot   = cnt_i[ROT_W-1:0];
  assign ror_w = (val_i >> rot) | (val_i << (DATA_W - int'(rot)));

  always_comb begin
    case (op_i)
      OP_LSL:  begin res_o = lsl_w[DATA_W-1:0]; cout_o = lsl_w[DATA_W]; end
      OP_LSR:  begin res_o = lsr_w[DATA_W:1];   cout_o = lsr_w[0];      end
      OP_ASR:  begin res_o = asr_w[DATA_W:1];   cout_o = asr_w[0];      end
      OP_ROR:  begin res_o = ror_w;             cout_o = ror_w[DATA_W-1]; end
      OP_RRX:  begin res_o = {cin_i, val_i[DATA_W-1:1]}; cout_o = val_i[0]; end
      default: begin res_o = val_i;             cout_o = cin_i;         end
    endcase
  end

  always_comb begin
    if (op_i == OP_LSL && cnt_i > CNT_W'(DATA_W))
      assert_lsl_wide_R7: assert (res_o == '0 && !cout_o)
        else $error("wide left shift not cleared");
    if (op_i == OP_LSR && cnt_i > CNT_W'(DATA_W))
      assert_lsr_wide_R8: assert (res_o == '0 && !cout_o)
        else $error("wide right shift not cleared");
    if (op_i == OP_ASR && cnt_i >= CNT_W'(DATA_W))
      assert_asr_fill_R9: assert (res_o == {DATA_W{val_i[DATA_W-1]}} && cout_o == val_i[DATA_W-1])
        else $error("wide arithmetic shift not sign filled");
    if (op_i == OP_ROR && rot == '0)
      assert_ror_whole_R10: assert (res_o == val_i && cout_o == val_i[DATA_W-1])
        else $error("rotate by multiple of width altered value");
    if (op_i == OP_RRX)
      assert_rrx_R5: assert (res_o[DATA_W-1] == cin_i && res_o[DATA_W-2:0] == val_i[DATA_W-1:1]
                             && cout_o == val_i[0])
        else $error("rotate through carry wrong");
  end

endmodule

// File: rtl/imm_rotator.sv
module imm_rotator #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 12,
  parameter int CONST_W = 8
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [DATA_W-1:0]  res_o
);

  localparam int ROT_W = FIELD_W - CONST_W;

  logic [DATA_W-1:0] base;
  logic [ROT_W:0]    amt;

  assign base  = DATA_W'(field_i[CONST_W-1:0]);
  assign amt   = {field_i[FIELD_W-1:CONST_W], 1'b0};
  assign res_o = (base >> amt) | (base << (DATA_W - int'(amt)));

  // rotation keeps the population count of the constant
  always_comb begin
    assert_const_bits_R11: assert ($countones(res_o) == $countones(field_i[CONST_W-1:0]))
      else $error("constant rotation lost bits");
  end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opshift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 12,
  parameter int CNT_W   = 8,
  parameter int CONST_W = 8
) (
  input  logic               const_sel_i,
  input  logic               amt_src_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic [DATA_W-1:0]  value_i,
  input  logic [DATA_W-1:0]  amt_reg_i,
  input  logic               carry_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               carry_o
);

  localparam int AMT_LSB = FIELD_W - $clog2(DATA_W);

  core_op_e          op;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh_res;
  logic              sh_cout;
  logic [DATA_W-1:0] k_res;

  shamt_decode #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_dec (
    .field_i  (field_i),
    .amt_src_i(amt_src_i),
    .amt_reg_i(amt_reg_i),
    .op_o     (op),
    .cnt_o    (cnt)
  );

  barrel_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .op_i  (op),
    .cnt_i (cnt),
    .val_i (value_i),
    .cin_i (carry_i),
    .res_o (sh_res),
    .cout_o(sh_cout)
  );

  imm_rotator #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .CONST_W(CONST_W)) u_krot (
    .field_i(field_i),
    .res_o  (k_res)
  );

  assign result_o = const_sel_i ? k_res : sh_res;
  assign carry_o  = const_sel_i ? carry_i : sh_cout;

  always_comb begin
    if (const_sel_i)
      assert_const_carry_R11: assert (carry_o == carry_i)
        else $error("constant form changed carry");
    if (!const_sel_i && amt_src_i && amt_reg_i[CNT_W-1:0] == '0)
      assert_reg_zero_pass_R6: assert (result_o == value_i && carry_o == carry_i)
        else $error("zero register amount not a pass-through");
    if (!const_sel_i && !amt_src_i && field_i[FIELD_W-1:AMT_LSB-2] == '0)
      assert_lsl_zero_pass_R3: assert (result_o == value_i && carry_o == carry_i)
        else $error("immediate left by zero not a pass-through");
  end

endmodule

// File: tb/opnd_shifter_tb.sv
module opnd_shifter_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        const_sel_i = 1'b0;
  logic        amt_src_i = 1'b0;
  logic [11:0] field_i = '0;
  logic [31:0] value_i = '0;
  logic [31:0] amt_reg_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  opnd_shifter u_dut (
    .const_sel_i(const_sel_i),
    .amt_src_i  (amt_src_i),
    .field_i    (field_i),
    .value_i    (value_i),
    .amt_reg_i  (amt_reg_i),
    .carry_i    (carry_i),
    .result_o   (result_o),
    .carry_o    (carry_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        csel;
    logic        asrc;
    logic [11:0] fld;
    logic [31:0] val;
    logic [31:0] amt;
    logic        cin;
    logic [31:0] eres;
    logic        ecar;
  } vec_t;

  localparam logic [1:0] T_LSL = 2'd0, T_LSR = 2'd1, T_ASR = 2'd2, T_ROR = 2'd3;
  localparam int NV = 40;

  localparam vec_t VECS [NV] = '{
    // R1 / R2: ordinary immediate amounts
    '{4'd1, 1'b0, 1'b0, {5'd4, T_LSL, 5'd0}, 32'h1234_5678, 32'hAAAA_AAAA, 1'b0, 32'h2345_6780, 1'b1},
    '{4'd1, 1'b0, 1'b0, {5'd8, T_LSR, 5'd0}, 32'h8765_4321, 32'h0, 1'b1, 32'h0087_6543, 1'b0},
    '{4'd1, 1'b0, 1'b0, {5'd4, T_ASR, 5'd0}, 32'h8000_00F8, 32'h0, 1'b0, 32'hF800_000F, 1'b1},
    '{4'd1, 1'b0, 1'b0, {5'd8, T_ROR, 5'd0}, 32'h1234_56A8, 32'h0, 1'b0, 32'hA812_3456, 1'b1},
    '{4'd2, 1'b0, 1'b0, {5'd31, T_LSL, 5'd0}, 32'h0000_0001, 32'h0, 1'b1, 32'h8000_0000, 1'b0},
    '{4'd2, 1'b0, 1'b1, {5'd0, T_LSL, 5'd0}, 32'h0000_0002, 32'h0000_001F, 1'b0, 32'h0, 1'b1},
    '{4'd2, 1'b0, 1'b1, {5'd0, T_LSR, 5'd0}, 32'h0000_0003, 32'h0000_0001, 1'b0, 32'h0000_0001, 1'b1},
    '{4'd2, 1'b0, 1'b0, {5'd1, T_ASR, 5'd0}, 32'h8000_0003, 32'h0, 1'b0, 32'hC000_0001, 1'b1},
    // R3: immediate left by zero
    '{4'd3, 1'b0, 1'b0, {5'd0, T_LSL, 5'd0}, 32'hDEAD_BEEF, 32'h0000_0008, 1'b1, 32'hDEAD_BEEF, 1'b1},
    '{4'd3, 1'b0, 1'b0, {5'd0, T_LSL, 5'd0}, 32'hDEAD_BEEF, 32'h0000_0008, 1'b0, 32'hDEAD_BEEF, 1'b0},
    // R4: encoded zero means 32 for right shifts
    '{4'd4, 1'b0, 1'b0, {5'd0, T_LSR, 5'd0}, 32'h8000_0000, 32'h0, 1'b0, 32'h0, 1'b1},
    '{4'd4, 1'b0, 1'b0, {5'd0, T_LSR, 5'd0}, 32'h7FFF_FFFF, 32'h0, 1'b1, 32'h0, 1'b0},
    '{4'd4, 1'b0, 1'b0, {5'd0, T_ASR, 5'd0}, 32'h7FFF_FFFF, 32'h0, 1'b1, 32'h0, 1'b0},
    '{4'd4, 1'b0, 1'b0, {5'd0, T_ASR, 5'd0}, 32'h8000_0000, 32'h0, 1'b0, 32'hFFFF_FFFF, 1'b1},
    // R5: rotate through carry
    '{4'd5, 1'b0, 1'b0, {5'd0, T_ROR, 5'd0}, 32'h0000_0003, 32'h0, 1'b1, 32'h8000_0001, 1'b1},
    '{4'd5, 1'b0, 1'b0, {5'd0, T_ROR, 5'd0}, 32'h8000_0002, 32'h0, 1'b0, 32'h4000_0001, 1'b0},
    // R6: register amount, low byte only
    '{4'd6, 1'b0, 1'b1, {5'd0, T_LSL, 5'd0}, 32'h1234_5678, 32'h0000_0100, 1'b0, 32'h1234_5678, 1'b0},
    '{4'd6, 1'b0, 1'b1, {5'd0, T_ROR, 5'd0}, 32'h0F0F_0F0F, 32'hFFFF_FF00, 1'b1, 32'h0F0F_0F0F, 1'b1},
    '{4'd6, 1'b0, 1'b1, {5'd0, T_ASR, 5'd0}, 32'h8000_0001, 32'h0000_0000, 1'b0, 32'h8000_0001, 1'b0},
    '{4'd6, 1'b0, 1'b1, {5'd0, T_LSR, 5'd0}, 32'h0000_00F0, 32'hFFFF_FF04, 1'b1, 32'h0000_000F, 1'b0},
    '{4'd6, 1'b0, 1'b1, {5'd3, T_LSL, 5'd0}, 32'h0000_0001, 32'h0000_0002, 1'b1, 32'h0000_0004, 1'b0},
    // R7: left by 32 and beyond
    '{4'd7, 1'b0, 1'b1, {5'd0, T_LSL, 5'd0}, 32'h0000_0001, 32'h0000_0020, 1'b0, 32'h0, 1'b1},
    '{4'd7, 1'b0, 1'b1, {5'd0, T_LSL, 5'd0}, 32'hFFFF_FFFF, 32'h0000_0021, 1'b1, 32'h0, 1'b0},
    '{4'd7, 1'b0, 1'b1, {5'd0, T_LSL, 5'd0}, 32'hFFFF_FFFF, 32'h0000_00FF, 1'b1, 32'h0, 1'b0},
    // R8: right by 32 and beyond
    '{4'd8, 1'b0, 1'b1, {5'd0, T_LSR, 5'd0}, 32'h8000_0000, 32'h0000_0020, 1'b0, 32'h0, 1'b1},
    '{4'd8, 1'b0, 1'b1, {5'd0, T_LSR, 5'd0}, 32'hFFFF_FFFF, 32'h0000_0028, 1'b1, 32'h0, 1'b0},
    '{4'd8, 1'b0, 1'b1, {5'd0, T_LSR, 5'd0}, 32'hFFFF_FFFF, 32'h0000_0021, 1'b1, 32'h0, 1'b0},
    // R9: arithmetic right by 32 and beyond
    '{4'd9, 1'b0, 1'b1, {5'd0, T_ASR, 5'd0}, 32'h8000_0000, 32'h0000_0020, 1'b0, 32'hFFFF_FFFF, 1'b1},
    '{4'd9, 1'b0, 1'b1, {5'd0, T_ASR, 5'd0}, 32'h7000_0000, 32'h0000_00C8, 1'b1, 32'h0, 1'b0},
    '{4'd9, 1'b0, 1'b1, {5'd0, T_ASR, 5'd0}, 32'h9000_0000, 32'h0000_0021, 1'b0, 32'hFFFF_FFFF, 1'b1},
    // R10: rotate modulo 32
    '{4'd10, 1'b0, 1'b1, {5'd0, T_ROR, 5'd0}, 32'h8000_1234, 32'h0000_0020, 1'b0, 32'h8000_1234, 1'b1},
    '{4'd10, 1'b0, 1'b1, {5'd0, T_ROR, 5'd0}, 32'h0000_1234, 32'h0000_0040, 1'b1, 32'h0000_1234, 1'b0},
    '{4'd10, 1'b0, 1'b1, {5'd0, T_ROR, 5'd0}, 32'h0000_00F1, 32'h0000_0024, 1'b1, 32'h1000_000F, 1'b0},
    '{4'd10, 1'b0, 1'b1, {5'd0, T_ROR, 5'd0}, 32'h0000_0001, 32'h0000_0021, 1'b0, 32'h8000_0000, 1'b1},
    // R11: rotated constant
    '{4'd11, 1'b1, 1'b0, {4'h4, 8'hFF}, 32'hFFFF_FFFF, 32'h0, 1'b0, 32'hFF00_0000, 1'b0},
    '{4'd11, 1'b1, 1'b0, {4'h0, 8'h85}, 32'hFFFF_FFFF, 32'h0, 1'b1, 32'h0000_0085, 1'b1},
    '{4'd11, 1'b1, 1'b0, {4'h1, 8'h03}, 32'h1234_5678, 32'h0, 1'b0, 32'hC000_0000, 1'b0},
    '{4'd11, 1'b1, 1'b1, {4'hF, 8'h01}, 32'hFFFF_FFFF, 32'h0000_0003, 1'b1, 32'h0000_0004, 1'b1},
    '{4'd11, 1'b1, 1'b1, {4'h8, 8'hA5}, 32'h0, 32'h0000_0000, 1'b0, 32'h00A5_0000, 1'b0},
    '{4'd1, 1'b0, 1'b0, {5'd16, T_ROR, 5'd0}, 32'h1234_8765, 32'h0000_0004, 1'b0, 32'h8765_1234, 1'b1}
  };

  task automatic apply(input vec_t v);
    @(posedge clk);
    const_sel_i = v.csel;
    amt_src_i   = v.asrc;
    field_i     = v.fld;
    value_i     = v.val;
    amt_reg_i   = v.amt;
    carry_i     = v.cin;
    @(negedge clk);
  endtask

  task automatic check(input int req, input logic [31:0] eres, input logic ecar);
    checks++;
    if (result_o !== eres || carry_o !== ecar) begin
      errors++;
      $display("FAIL R%0d: result=%h carry=%b expected result=%h carry=%b",
               req, result_o, carry_o, eres, ecar);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // all-zero inputs right after reset: zero operand, zero carry (R3 pass-through)
    @(negedge clk);
    check(3, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check(int'(VECS[i].req), VECS[i].eres, VECS[i].ecar);
    end

    // R11: value_i and amt_reg_i changes must not move the constant form
    apply('{4'd11, 1'b1, 1'b0, {4'h2, 8'h0F}, 32'h1111_1111, 32'h0000_0005, 1'b1, 32'hF000_0000, 1'b1});
    check(11, 32'hF000_0000, 1'b1);
    value_i = 32'hFFFF_0000; amt_reg_i = 32'hFFFF_FFFF;
    @(negedge clk);
    check(11, 32'hF000_0000, 1'b1);

    // R6: immediate amount bits ignored in register form, upper amount bits ignored
    apply('{4'd6, 1'b0, 1'b1, {5'd31, T_LSR, 5'd0}, 32'h8000_0000, 32'h1234_5601, 1'b0, 32'h4000_0000, 1'b0});
    check(6, 32'h4000_0000, 1'b0);

    // R1: amt_reg_i ignored in immediate form
    apply('{4'd1, 1'b0, 1'b0, {5'd1, T_LSL, 5'd0}, 32'h4000_0001, 32'h0000_00FF, 1'b0, 32'h8000_0002, 1'b0});
    check(1, 32'h8000_0002, 1'b0);

    finish_run();
  end

  initial begin
    for (int c = 0; c < 10000; c++) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

endmodule